// File: doc/BRIEF.md
# Power-Domain Request/Ack Controller with Timeout

This controller runs one power transition at a time for ten peripheral power domains. A caller presents a domain code (a 12-bit offset value) and a wanted level (on or off) for one cycle. A known code makes the block raise a global enable bit and post a single request bit. The request bit sits at the domain's on index for a power-on and at that index plus ten for a power-off. The block then polls three feedback inputs from an external power-management engine until all three show the wanted level: a per-domain completion bit, a primary status bit and a secondary status bit.

Polls happen on ticks of an internal prescaler. The first poll is taken one cycle after acceptance, and each later poll comes `PRESC` cycles after the one before. If the domain has not settled once `MAX_POLLS` polls have failed, the next failing poll ends the operation as an error. An operation ends in one of two ways: a one-cycle `done` pulse with `err` low on success, or with `err` high on timeout or on an unknown code. On either ending the request vector returns to zero and the enable bit drops. An unknown code is rejected at once and no request is posted.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset `req_vec` is zero and `ctl_en`, `done` and `err` are low.
- R2: A request taken while idle with a known code sets `ctl_en` and exactly one bit of `req_vec` in the next cycle. The bit is at the domain's on index for `want_on`=1 and at that index plus 10 for `want_on`=0. On indices 0 to 9 belong to codes 0x210, 0x230, 0x238, 0x23c, 0x298, 0x29c, 0x2c4, 0x2c0, 0x214, 0x2cc, in that order.
- R3: The status bit polled on both status inputs depends on the code: 0x210 uses 7, 0x230 uses 21, 0x238 uses 5, 0x23c uses 3, 0x298 uses 20, 0x29c uses 24, 0x2c4 uses 23, 0x2c0 uses 22, 0x214 uses 4, 0x2cc uses 25. The completion bit polled is `ack_bits` at the domain's on index.
- R4: Polls take place at the clock edges 1, 1+PRESC, 1+2·PRESC, … after the accepting edge. The first poll that finds all three selected bits equal to `want_on` gives `done`=1 and `err`=0 right after that edge.
- R5: If MAX_POLLS polls have failed, a further failing poll gives `done`=1 and `err`=1. This poll is at edge 1+MAX_POLLS·PRESC after acceptance.
- R6: Whenever `done` is high, `req_vec` is zero and `ctl_en` is low. `done` lasts exactly one cycle.
- R7: An unknown code gives `done`=1 and `err`=1 in the cycle after acceptance. `req_vec` stays zero and `ctl_en` stays low.
- R8: `req_valid` is ignored while an operation is in progress. `req_vec` keeps its value.
- R9: A poll where only two of the three selected bits match `want_on` counts as a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| want_on | input | 1 | Wanted level: 1 = power on, 0 = power off |
| dom_code | input | CODE_W | Domain offset code |
| ack_bits | input | 10 | Completion bits, one per on index |
| sta_pri | input | STA_W | Primary power status word |
| sta_sec | input | STA_W | Secondary power status word |
| req_vec | output | 20 | One-hot request vector (on 0–9, off 10–19) |
| ctl_en | output | 1 | Global control enable, high during an operation |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Qualifies `done`: timeout or unknown code |

## Verification
The assertions assume three things about the inputs. The feedback words are synchronous to `clk`. A caller does not expect a request to be taken while `ctl_en` is high. The engine's feedback stays settled once it has reached the wanted level. The stimulus meets these assumptions by changing every input only on the falling clock edge. It applies the feedback all at once at a chosen cycle after acceptance and holds it until the operation ends. It holds every unselected feedback bit at the opposite level, so that a wrong bit selection can only show up as a late or failed result, never as an early one.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   localparam int NUM_DOM = 10;
   localparam int REQ_W   = 2 * NUM_DOM;
   localparam int OIDX_W  = $clog2(NUM_DOM);
   localparam int RB_W    = $clog2(REQ_W);

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } pdc_state_e;
endpackage

// File: rtl/pdc_decoder.sv
module pdc_decoder
   import pdc_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int SIDX_W = 5
) (
   input  logic [CODE_W-1:0] code,
   output logic              hit,
   output logic [OIDX_W-1:0] on_idx,
   output logic [SIDX_W-1:0] sta_idx
);
   always_comb begin
      hit     = 1'b1;
      on_idx  = '0;
      sta_idx = '0;
      case (code)
         CODE_W'(12'h210): begin on_idx = OIDX_W'(0); sta_idx = SIDX_W'(7);  end
         CODE_W'(12'h230): begin on_idx = OIDX_W'(1); sta_idx = SIDX_W'(21); end
         CODE_W'(12'h238): begin on_idx = OIDX_W'(2); sta_idx = SIDX_W'(5);  end
         CODE_W'(12'h23c): begin on_idx = OIDX_W'(3); sta_idx = SIDX_W'(3);  end
         CODE_W'(12'h298): begin on_idx = OIDX_W'(4); sta_idx = SIDX_W'(20); end
         CODE_W'(12'h29c): begin on_idx = OIDX_W'(5); sta_idx = SIDX_W'(24); end
         CODE_W'(12'h2c4): begin on_idx = OIDX_W'(6); sta_idx = SIDX_W'(23); end
         CODE_W'(12'h2c0): begin on_idx = OIDX_W'(7); sta_idx = SIDX_W'(22); end
         CODE_W'(12'h214): begin on_idx = OIDX_W'(8); sta_idx = SIDX_W'(4);  end
         CODE_W'(12'h2cc): begin on_idx = OIDX_W'(9); sta_idx = SIDX_W'(25); end
         default:          hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/pdc_agree.sv
module pdc_agree
   import pdc_pkg::*;
#(
   parameter int STA_W  = 32,
   parameter int SIDX_W = 5
) (
   input  logic [NUM_DOM-1:0] ack_bits,
   input  logic [STA_W-1:0]   sta_pri,
   input  logic [STA_W-1:0]   sta_sec,
   input  logic [OIDX_W-1:0]  on_idx,
   input  logic [SIDX_W-1:0]  sta_idx,
   input  logic               want,
   output logic               match
);
   logic ack_sel, pri_sel, sec_sel;

   always_comb begin
      ack_sel = ack_bits[on_idx];
      pri_sel = sta_pri[sta_idx];
      sec_sel = sta_sec[sta_idx];
      match   = (ack_sel == want) && (pri_sel == want) && (sec_sel == want);
   end
endmodule

// File: rtl/pdc_poll_timer.sv
module pdc_poll_timer #(
   parameter int PRESC     = 1000,
   parameter int MAX_POLLS = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic miss,
   output logic tick,
   output logic last
);
   localparam int FW = $clog2(MAX_POLLS + 1);

   logic [FW-1:0] fails;

   always_ff @(posedge clk) begin
      if (!rst_n)                   fails <= '0;
      else if (clear)               fails <= '0;
      else if (tick && miss && !last) fails <= fails + FW'(1);
   end

   assign last = (fails == FW'(MAX_POLLS));

   generate
      if (PRESC == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_prescaled
         localparam int PW = $clog2(PRESC);
         logic [PW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                      cnt <= '0;
            else if (clear)                  cnt <= '0;
            else if (cnt == PW'(PRESC - 1))  cnt <= '0;
            else                             cnt <= cnt + PW'(1);
         end
         assign tick = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
   import pdc_pkg::*;
#(
   parameter int CODE_W    = 12,
   parameter int STA_W     = 32,
   parameter int PRESC     = 1000,
   parameter int MAX_POLLS = 10000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               want_on,
   input  logic [CODE_W-1:0]  dom_code,
   input  logic [NUM_DOM-1:0] ack_bits,
   input  logic [STA_W-1:0]   sta_pri,
   input  logic [STA_W-1:0]   sta_sec,
   output logic [REQ_W-1:0]   req_vec,
   output logic               ctl_en,
   output logic               done,
   output logic               err
);
   localparam int SIDX_W = $clog2(STA_W);

   generate
      if (CODE_W < 10) begin : g_bad_code_w
         $error("CODE_W must hold the 10-bit domain codes");
      end
      if (STA_W < 26) begin : g_bad_sta_w
         $error("STA_W must cover status bit 25");
      end
      if (PRESC < 1) begin : g_bad_presc
         $error("PRESC must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
   endgenerate

   pdc_state_e        state;
   logic              want_q;
   logic [OIDX_W-1:0] on_q;
   logic [SIDX_W-1:0] sta_q;

   logic              dec_hit;
   logic [OIDX_W-1:0] dec_on;
   logic [SIDX_W-1:0] dec_sta;
   logic              match, tick, last;
   logic [RB_W-1:0]   req_bit;

   pdc_decoder #(.CODE_W(CODE_W), .SIDX_W(SIDX_W)) u_dec (
      .code(dom_code), .hit(dec_hit), .on_idx(dec_on), .sta_idx(dec_sta)
   );

   pdc_agree #(.STA_W(STA_W), .SIDX_W(SIDX_W)) u_agree (
      .ack_bits(ack_bits), .sta_pri(sta_pri), .sta_sec(sta_sec),
      .on_idx(on_q), .sta_idx(sta_q), .want(want_q), .match(match)
   );

   pdc_poll_timer #(.PRESC(PRESC), .MAX_POLLS(MAX_POLLS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
      .miss(!match), .tick(tick), .last(last)
   );

   assign req_bit = want_on ? RB_W'(dec_on) : RB_W'(dec_on) + RB_W'(NUM_DOM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         want_q  <= 1'b0;
         on_q    <= '0;
         sta_q   <= '0;
         req_vec <= '0;
         ctl_en  <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (dec_hit) begin
                     state   <= ST_WAIT;
                     want_q  <= want_on;
                     on_q    <= dec_on;
                     sta_q   <= dec_sta;
                     req_vec <= REQ_W'(1) << req_bit;
                     ctl_en  <= 1'b1;
                  end else begin
                     done <= 1'b1;
                     err  <= 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (tick && (match || last)) begin
                  state   <= ST_IDLE;
                  req_vec <= '0;
                  ctl_en  <= 1'b0;
                  done    <= 1'b1;
                  err     <= !match;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker
   import pdc_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [REQ_W-1:0] req_vec,
   input logic             ctl_en,
   input logic             done,
   input logic             err
);
   a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_en |-> ($countones(req_vec) == 1));

   a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> (req_vec == '0));

   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ctl_en);

   a_r5_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && $past(ctl_en)) |-> $stable(req_vec));

   a_r7_start_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_en) |-> !done);
endmodule

bind pwr_dom_ctrl pdc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_vec(req_vec),
   .ctl_en(ctl_en), .done(done), .err(err)
);

// File: tb/pwr_dom_ctrl_test.sv
module pwr_dom_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int P  = 3;
   localparam int MX = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        want_on = 1'b0;
   logic [11:0] dom_code = '0;
   logic [9:0]  ack_bits = '0;
   logic [31:0] sta_pri = '0;
   logic [31:0] sta_sec = '0;
   logic [19:0] req_vec;
   logic        ctl_en, done, err;

   int checks = 0;
   int fails  = 0;

   logic [11:0] codes [10];
   int          sbit  [10];

   pwr_dom_ctrl #(.CODE_W(12), .STA_W(32), .PRESC(P), .MAX_POLLS(MX)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .want_on(want_on),
      .dom_code(dom_code), .ack_bits(ack_bits), .sta_pri(sta_pri),
      .sta_sec(sta_sec), .req_vec(req_vec), .ctl_en(ctl_en),
      .done(done), .err(err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // miss: -1 none, 0 ack bit, 1 primary, 2 secondary left unmatched (R9)
   task automatic run_op(input int d, input bit on, input int r, input int miss, input bit poke);
      int  k, lat, seen;
      bit  ok;
      logic [19:0] exp_req;
      k   = (r - 1 + P - 1) / P;
      ok  = (miss < 0) && (k <= MX);
      lat = ok ? 1 + k * P : 1 + MX * P;
      exp_req = 20'(1) << (on ? d : d + 10);
      @(negedge clk);
      ack_bits  = on ? '0 : '1;
      sta_pri   = on ? '0 : '1;
      sta_sec   = on ? '0 : '1;
      req_valid = 1'b1;
      want_on   = on;
      dom_code  = codes[d];
      @(posedge clk);
      seen = -1;
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         if (j == 0) begin
            req_valid = 1'b0;
            check(req_vec == exp_req, "R2 request vector", req_vec, exp_req);
            check(ctl_en == 1'b1, "R2 enable raised", ctl_en, 1);
         end
         if (j == 1 && poke) begin
            check(req_vec == exp_req, "R8 request ignored while busy", req_vec, exp_req);
            req_valid = 1'b0;
         end
         if (done) begin
            seen = j;
            break;
         end
         if (j == 0 && poke) begin
            req_valid = 1'b1;
            dom_code  = codes[(d + 1) % 10];
            want_on   = !on;
         end
         if (j == r - 1) begin
            if (miss != 0) ack_bits[d]       = on;
            if (miss != 1) sta_pri[sbit[d]]  = on;
            if (miss != 2) sta_sec[sbit[d]]  = on;
         end
      end
      req_valid = 1'b0;
      check(seen == lat, ok ? "R3/R4 completion cycle" : "R5/R9 timeout cycle", seen, lat);
      check(err == !ok, ok ? "R4 success flag" : "R5/R9 error flag", err, !ok);
      check(req_vec == '0 && !ctl_en, "R6 released at done", {req_vec, ctl_en}, 0);
      @(negedge clk);
      check(!done, "R6 done single cycle", done, 0);
   endtask

   task automatic run_bad(input logic [11:0] c);
      @(negedge clk);
      req_valid = 1'b1;
      dom_code  = c;
      want_on   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(done && err, "R7 unknown code error", {done, err}, 3);
      check(req_vec == '0 && !ctl_en, "R7 no request posted", {req_vec, ctl_en}, 0);
      @(negedge clk);
      check(!done && !ctl_en, "R7 ends after one cycle", {done, ctl_en}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      codes[0] = 12'h210; sbit[0] = 7;
      codes[1] = 12'h230; sbit[1] = 21;
      codes[2] = 12'h238; sbit[2] = 5;
      codes[3] = 12'h23c; sbit[3] = 3;
      codes[4] = 12'h298; sbit[4] = 20;
      codes[5] = 12'h29c; sbit[5] = 24;
      codes[6] = 12'h2c4; sbit[6] = 23;
      codes[7] = 12'h2c0; sbit[7] = 22;
      codes[8] = 12'h214; sbit[8] = 4;
      codes[9] = 12'h2cc; sbit[9] = 25;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(req_vec == '0 && !ctl_en && !done && !err, "R1 reset state",
            {req_vec, ctl_en, done, err}, 0);

      for (int d = 0; d < 10; d++) begin
         for (int on = 0; on < 2; on++) begin
            run_op(d, 1'(on), 1, -1, 1'b0);
            run_op(d, 1'(on), 2, -1, 1'b1);
            run_op(d, 1'(on), 5, -1, 1'b0);
            run_op(d, 1'(on), 1 + MX * P, -1, 1'b0);
            run_op(d, 1'(on), 2 + MX * P, -1, 1'b0);
         end
      end
      for (int m = 0; m < 3; m++) begin
         run_op(m * 3, 1'b1, 1, m, 1'b0);
         run_op(m * 3 + 1, 1'b0, 1, m, 1'b0);
      end
      run_bad(12'h000);
      run_bad(12'h211);
      run_bad(12'h2c8);
      run_bad(12'hfff);
      run_op(9, 1'b1, 1, -1, 1'b0);
      report();
   end
endmodule